// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the software-visible registers of a simple single-channel DMA engine that serves a SCSI controller. Software reaches four 32-bit registers, chosen by word index: a control/status word, a memory address word and two spare storage words. Control writes are not stored verbatim. The block rewrites them first: it handles a controller reset request and a self-clearing status bit, and it forces a version code into the top nibble.

Programming the address word stores the address. It also replaces the control word with a single "address loaded" flag. The attached controller reports transfer completion through a pulse, which latches a completion flag in the control word. A separate request input raises the shared interrupt line. A control write with the interrupt-enable bit clear drops that line again. Bit 8 of the control word is exported as the transfer direction. Bus mastering and address translation sit outside this block.

Top module: `dmac_chan_regs`

## Requirements
- R1: The register is chosen by address bits [3:2]: 0 is control, 1 is address, 2 and 3 are spare. When rd_en is high, rd_data takes the selected register's stored value on the next clock edge and keeps it otherwise. Reads change no state.
- R2: Rewriting of a control write:
  - If bit 7 is set, the bits are kept as written.
  - Otherwise, if bit 6 is set, bit 6 is stored as 0.
  - Otherwise, if the whole written value is zero, bit 6 is stored as 1.
- R3: Every control write stores bits [31:28] as 0xA, whatever was written there. After reset the control word reads 0xA0000000.
- R4: A control write with bit 7 set raises rst_req for exactly the one cycle after the write. No other write raises it.
- R5: A write to the address register stores the written value there. It also sets the control word to 0x04000000 (bit 26 only).
- R6: A xfer_done pulse sets control bit 0 on the next edge. This applies even when a control or address write lands in the same cycle.
- R7: irq_raise sets irq_out on the next edge. A control write with bit 4 clear clears irq_out, unless irq_raise is high in the same cycle. A control write with bit 4 set leaves irq_out unchanged.
- R8: dir_to_mem equals control bit 8 (1 means data flows into memory).
- R9: The spare registers 2 and 3 store whatever is written. Writing them leaves the control and address registers unchanged.
- R10: After reset, the address and spare registers read 0, and irq_out, rst_req and dir_to_mem are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | DATA_W | Registered read data |
| xfer_done | input | 1 | Completion pulse from the controller |
| irq_raise | input | 1 | Interrupt request from the controller |
| irq_out | output | 1 | Gated shared interrupt line |
| rst_req | output | 1 | One-cycle reset request to the controller |
| dir_to_mem | output | 1 | Transfer direction, high for writes into memory |

## Verification
On every cycle, the assertions check several cycle-to-cycle relations:
- the reset request follows a control write with bit 7 set, and only such a write;
- the version nibble after each control write;
- the zero-write default;
- the loaded flag after an address write;
- the completion flag after xfer_done;
- the set/clear priority of the interrupt line.

Only the bench scenarios show the exact stored value of each rewrite case. They also show the read-back of the address and spare words, the fact that reads have no side effects, the direction output, and the merged control value when completion and an address write coincide.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    IDX_CTRL   = 2'd0,
    IDX_ADDR   = 2'd1,
    IDX_SPARE0 = 2'd2,
    IDX_SPARE1 = 2'd3
  } reg_idx_e;

  localparam int REG_COUNT  = 4;
  localparam int DONE_BIT   = 0;
  localparam int IE_BIT     = 4;
  localparam int TOGGLE_BIT = 6;
  localparam int RESET_BIT  = 7;
  localparam int DIR_BIT    = 8;
  localparam int LOADED_BIT = 26;
endpackage

// File: rtl/dmac_ctrl_rewrite.sv
module dmac_ctrl_rewrite
  import dmac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VER_W   = 4,
  parameter logic [VER_W-1:0] VERSION = 4'hA
) (
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stored,
  output logic              reset_hit
);
  logic [DATA_W-1:0] shaped;

  assign reset_hit = wdata[RESET_BIT];

  always_comb begin
    shaped = wdata;
    if (wdata[RESET_BIT]) begin
      shaped = wdata;
    end else if (wdata[TOGGLE_BIT]) begin
      shaped[TOGGLE_BIT] = 1'b0;
    end else if (wdata == '0) begin
      shaped[TOGGLE_BIT] = 1'b1;
    end
    stored = shaped;
    stored[DATA_W-1 -: VER_W] = VERSION;
  end
endmodule

// File: rtl/dmac_irq_gate.sv
module dmac_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic drop,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (raise) begin
      irq <= 1'b1;
    end else if (drop) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dmac_spare_regs.sv
module dmac_spare_regs #(
  parameter int DATA_W  = 32,
  parameter int N_SPARE = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_SPARE-1:0]             wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [N_SPARE-1:0][DATA_W-1:0] value
);
  for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
    always_ff @(posedge clk) begin
      if (rst) begin
        value[g] <= '0;
      end else if (wr_sel[g]) begin
        value[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int VER_W  = 4,
  parameter logic [VER_W-1:0] VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xfer_done,
  input  logic              irq_raise,
  output logic              irq_out,
  output logic              rst_req,
  output logic              dir_to_mem
);
  localparam int IDX_LSB = 2;
  localparam int N_SPARE = REG_COUNT - 2;
  localparam logic [DATA_W-1:0] CTRL_RST   = {VERSION, {(DATA_W-VER_W){1'b0}}};
  localparam logic [DATA_W-1:0] LOADED_VAL = DATA_W'(1) << LOADED_BIT;

  logic [1:0]        idx;
  logic              ctrl_wr, addr_wr;
  logic [DATA_W-1:0] ctrl_q, ctrl_next, addr_q, ctrl_rewritten;
  logic              reset_hit;
  logic [N_SPARE-1:0]             spare_sel;
  logic [N_SPARE-1:0][DATA_W-1:0] spare_val;

  assign idx     = addr[IDX_LSB +: 2];
  assign ctrl_wr = wr_en && (idx == IDX_CTRL);
  assign addr_wr = wr_en && (idx == IDX_ADDR);

  for (genvar s = 0; s < N_SPARE; s++) begin : g_sel
    assign spare_sel[s] = wr_en && (idx == 2'(s + 2));
  end

  dmac_ctrl_rewrite #(.DATA_W(DATA_W), .VER_W(VER_W), .VERSION(VERSION)) u_rewrite (
    .wdata     (wr_data),
    .stored    (ctrl_rewritten),
    .reset_hit (reset_hit)
  );

  dmac_spare_regs #(.DATA_W(DATA_W), .N_SPARE(N_SPARE)) u_spare (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (spare_sel),
    .wr_data (wr_data),
    .value   (spare_val)
  );

  dmac_irq_gate u_irq (
    .clk   (clk),
    .rst   (rst),
    .raise (irq_raise),
    .drop  (ctrl_wr && !wr_data[IE_BIT]),
    .irq   (irq_out)
  );

  always_comb begin
    ctrl_next = ctrl_q;
    if (ctrl_wr) begin
      ctrl_next = ctrl_rewritten;
    end else if (addr_wr) begin
      ctrl_next = LOADED_VAL;
    end
    if (xfer_done) begin
      ctrl_next[DONE_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      addr_q  <= '0;
      rst_req <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_next;
      rst_req <= ctrl_wr && reset_hit;
      if (addr_wr) begin
        addr_q <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (idx)
        IDX_CTRL:   rd_data <= ctrl_q;
        IDX_ADDR:   rd_data <= addr_q;
        IDX_SPARE0: rd_data <= spare_val[0];
        default:    rd_data <= spare_val[N_SPARE-1];
      endcase
    end
  end

  assign dir_to_mem = ctrl_q[DIR_BIT];
endmodule

// File: rtl/dmac_chan_regs_chk.sv
module dmac_chan_regs_chk
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int VER_W  = 4,
  parameter logic [VER_W-1:0] VERSION = 4'hA
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              xfer_done,
  input logic              irq_raise,
  input logic              irq_out,
  input logic              rst_req,
  input logic [DATA_W-1:0] ctrl_q
);
  logic c_wr, a_wr;
  assign c_wr = wr_en && (addr[3:2] == 2'd0);
  assign a_wr = wr_en && (addr[3:2] == 2'd1);

  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    c_wr && wr_data[RESET_BIT] |=> rst_req);
  assert_rst_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(c_wr && wr_data[RESET_BIT]));
  assert_version_R3: assert property (@(posedge clk) disable iff (rst)
    c_wr |=> ctrl_q[DATA_W-1 -: VER_W] == VERSION);
  assert_zero_default_R2: assert property (@(posedge clk) disable iff (rst)
    c_wr && wr_data == '0 && !xfer_done |=> ctrl_q == {VERSION, {(DATA_W-VER_W-7){1'b0}}, 7'h40});
  assert_loaded_R5: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> ctrl_q[DATA_W-1:1] == (DATA_W-1)'(1 << (LOADED_BIT-1)));
  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> ctrl_q[DONE_BIT]);
  assert_irq_set_R7: assert property (@(posedge clk) disable iff (rst)
    irq_raise |=> irq_out);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (rst)
    c_wr && !wr_data[IE_BIT] && !irq_raise |=> !irq_out);
endmodule

bind dmac_chan_regs dmac_chan_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VER_W(VER_W), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .xfer_done(xfer_done), .irq_raise(irq_raise), .irq_out(irq_out),
  .rst_req(rst_req), .ctrl_q(ctrl_q)
);

// File: tb/tb_dmac_chan_regs.sv
module tb_dmac_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {write index, write data, read index, expected read}
  localparam logic [67:0] VECS [0:NV-1] = '{
    {2'd0, 32'h00000000, 2'd0, 32'hA0000040},  // R2 zero default
    {2'd0, 32'h00000040, 2'd0, 32'hA0000000},  // R2 bit6 cleared
    {2'd0, 32'h00000140, 2'd0, 32'hA0000100},  // R2
    {2'd0, 32'hFFFFFF3F, 2'd0, 32'hAFFFFF3F},  // R3 nibble forced
    {2'd0, 32'h12345678, 2'd0, 32'hA2345638},  // R2 R3
    {2'd0, 32'h000000C0, 2'd0, 32'hA00000C0},  // R2 bit7 keeps bit6
    {2'd0, 32'h00000080, 2'd0, 32'hA0000080},  // R2
    {2'd1, 32'hDEADBEEF, 2'd1, 32'hDEADBEEF},  // R5 address stored
    {2'd2, 32'h11111111, 2'd0, 32'h04000000},  // R5 loaded, R9 no effect
    {2'd3, 32'hCAFEF00D, 2'd3, 32'hCAFEF00D},  // R9
    {2'd2, 32'h55AA55AA, 2'd2, 32'h55AA55AA},  // R9
    {2'd0, 32'h50000010, 2'd0, 32'hA0000010}   // R3
  };

  logic clk = 0, rst = 1;
  logic [3:0] addr = '0;
  logic wr_en = 0, rd_en = 0, xfer_done = 0, irq_raise = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_out, rst_req, dir_to_mem;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_chan_regs dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .xfer_done(xfer_done),
    .irq_raise(irq_raise), .irq_out(irq_out), .rst_req(rst_req),
    .dir_to_mem(dir_to_mem)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drive on a falling edge, return on the next falling edge
  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    addr = {idx, 2'b00}; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    addr = {idx, 2'b00}; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 / R3 reset state
    rd(2'd0, r); check("R3 reset ctrl", r, 32'hA0000000);
    rd(2'd1, r); check("R10 reset addr", r, 32'h0);
    rd(2'd3, r); check("R10 reset spare", r, 32'h0);
    check("R10 reset outputs", {29'd0, irq_out, rst_req, dir_to_mem}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i][67:66], VECS[i][65:34]);
      rd(VECS[i][33:32], r);
      check($sformatf("R1 R2 R3 R5 R9 vector %0d", i), r, VECS[i][31:0]);
    end

    // R1 reads have no side effects
    rd(2'd0, r); rd(2'd0, r2); check("R1 repeated read", r2, r);

    // R4 reset pulse
    wr(2'd0, 32'h00000080);
    check("R4 pulse high", {31'd0, rst_req}, 32'd1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, rst_req}, 32'd0);
    wr(2'd0, 32'h00000040);
    check("R4 no pulse without bit7", {31'd0, rst_req}, 32'd0);
    wr(2'd1, 32'hFFFFFFFF);
    check("R4 no pulse from address write", {31'd0, rst_req}, 32'd0);

    // R7 interrupt gating
    irq_raise = 1; @(negedge clk); irq_raise = 0;
    check("R7 raise", {31'd0, irq_out}, 32'd1);
    wr(2'd0, 32'h00000010);
    check("R7 bit4 set keeps", {31'd0, irq_out}, 32'd1);
    wr(2'd0, 32'h00000001);
    check("R7 bit4 clear drops", {31'd0, irq_out}, 32'd0);
    irq_raise = 1; wr(2'd0, 32'h0); irq_raise = 0;
    check("R7 raise wins", {31'd0, irq_out}, 32'd1);

    // R6 completion flag
    wr(2'd0, 32'h00000020);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    rd(2'd0, r); check("R6 done sets bit0", r, 32'hA0000021);
    xfer_done = 1; wr(2'd1, 32'h00001000); xfer_done = 0;
    rd(2'd0, r); check("R6 done with address write", r, 32'h04000001);
    xfer_done = 1; wr(2'd0, 32'h00000040); xfer_done = 0;
    rd(2'd0, r); check("R6 done with control write", r, 32'hA0000001);

    // R8 direction
    wr(2'd0, 32'h00000100);
    check("R8 direction into memory", {31'd0, dir_to_mem}, 32'd1);
    wr(2'd0, 32'h00000000);
    check("R8 direction from memory", {31'd0, dir_to_mem}, 32'd0);

    // R9 spare write leaves address intact
    wr(2'd3, 32'h0BADF00D);
    rd(2'd1, r); check("R9 address untouched", r, 32'h00001000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule